// File: doc/BRIEF.md
# Parallel FPGA Configuration Sequencer

This block runs on the host side of a board and loads a configuration image into a slave FPGA through the FPGA's byte-wide parallel configuration port. It first resets the target by pulling the active-low program line low for a minimum time, and it checks that the target's active-low init line and its done line both read low during that reset. It then releases program and waits, up to a bounded time, for init to return high. Once init is high, the block drops the active-low write line and lights the active-low status LED.

The image arrives as a ready/valid byte stream with a last flag. Every accepted byte is bit-reversed, because images are laid out for a serial loader. The byte is placed on the data bus, and a single one-clock chip-select strobe is issued for it. Trailing dummy bytes are treated like any other byte, since they provide the clocks the target needs to finish start-up.

After the last byte the block samples init and done and reports one of five outcomes: success, CRC error, done missing, init timeout, or reset failure. On success it returns write and the LED to idle. On any failure it parks the target in reset with write high and the LED off. The pulse width and the timeout are computed from the clock frequency parameter.

Top module: `fpga_cfg_loader`

## Requirements
- R1: After reset, cfg_prog_n, cfg_write_n, cfg_cs_n and cfg_led_n are all 1, busy is 0, s_ready is 0 and all five status flags are 0.
- R2: Each low pulse on cfg_prog_n lasts at least ceil(PROG_LOW_NS × CLK_FREQ_HZ / 1e9) clocks, which is 15 clocks at the default settings.
- R3: Suppose cfg_init_n or cfg_done reads 1 at the end of the reset pulse. Then err_reset is set, cfg_prog_n stays 0, and no byte is requested.
- R4: Suppose cfg_init_n stays 0 for INIT_WAIT_US microseconds (5000 clocks by default) after cfg_prog_n is released. Then err_init_to is set. During the wait, cfg_write_n and cfg_led_n stay 1.
- R5: cfg_write_n and cfg_led_n fall only in the clock after cfg_init_n has been seen high.
- R6: Each accepted stream byte produces exactly one cfg_cs_n low pulse, exactly one clock wide.
- R7: cfg_data carries the accepted byte with its bits reversed: input bit i appears on output bit 7-i. For example, 8'h01 is driven as 8'h80 and 8'h0F is driven as 8'hF0.
- R8: cfg_data is stable in the clock before, during and after every cfg_cs_n low clock.
- R9: One clock after the strobe of the byte flagged last, the outcome is decided as follows. cfg_init_n = 0 gives err_crc. Otherwise cfg_done = 0 gives err_done. Otherwise the outcome is ok.
- R10: On success, cfg_write_n, cfg_led_n and cfg_prog_n are all 1 when ok rises.
- R11: On err_init_to, err_crc or err_done, cfg_prog_n is driven to 0, cfg_write_n to 1 and cfg_led_n to 1.
- R12: s_ready is 1 only while waiting for a byte in the streaming phase. A start pulse while busy is 1 has no effect.
- R13: At most one status flag is 1 at a time. All flags clear when a new run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin a configuration run (ignored while busy) |
| s_data | input | 8 | Image byte |
| s_valid | input | 1 | Image byte valid |
| s_last | input | 1 | Marks the final image byte |
| s_ready | output | 1 | Sequencer accepts a byte |
| cfg_prog_n | output | 1 | Active-low program/reset to target |
| cfg_write_n | output | 1 | Active-low write enable to target |
| cfg_cs_n | output | 1 | Active-low chip-select strobe, one per byte |
| cfg_data | output | 8 | Bit-reversed configuration byte |
| cfg_led_n | output | 1 | Active-low status LED |
| cfg_init_n | input | 1 | Active-low init status from target |
| cfg_done | input | 1 | Done status from target |
| busy | output | 1 | Run in progress |
| ok | output | 1 | Run completed successfully |
| err_reset | output | 1 | Init or done not low during reset |
| err_init_to | output | 1 | Init did not rise in time |
| err_crc | output | 1 | Init low after the image (CRC error) |
| err_done | output | 1 | Done low after the image |

## Verification
A corrupted state register or byte counter shows at the ports within one byte time. The symptom is a strobe with no byte behind it, a second strobe for one byte, or a byte whose order is wrong on the bus. The scoreboard catches each of these at the strobe clock. A wrong reset-width or timeout count shows as a program pulse that is too short, or as an error flag that appears at the wrong time. These are measured in clocks from the start pulse. A wrong outcome decode shows as the wrong flag, or as the target left out of reset, one clock after the final strobe.

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader #(
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int PROG_LOW_NS = 300,
  parameter int INIT_WAIT_US = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  output logic       cfg_prog_n,
  output logic       cfg_write_n,
  output logic       cfg_cs_n,
  output logic [7:0] cfg_data,
  output logic       cfg_led_n,
  input  logic       cfg_init_n,
  input  logic       cfg_done,
  output logic       busy,
  output logic       ok,
  output logic       err_reset,
  output logic       err_init_to,
  output logic       err_crc,
  output logic       err_done
);
  localparam longint PROG_CYC_L = (longint'(PROG_LOW_NS) * CLK_FREQ_HZ + 64'd999_999_999) / 64'd1_000_000_000;
  localparam int PROG_CYC = (PROG_CYC_L < 1) ? 1 : int'(PROG_CYC_L);
  localparam longint TO_CYC_L = (longint'(INIT_WAIT_US) * CLK_FREQ_HZ + 64'd999_999) / 64'd1_000_000;
  localparam int TO_CYC = (TO_CYC_L < 1) ? 1 : int'(TO_CYC_L);
  localparam int MAXC = (TO_CYC > PROG_CYC) ? TO_CYC : PROG_CYC;
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PROG, S_WAIT, S_STREAM, S_SETUP, S_STROBE, S_HOLD, S_CHECK
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          last_q;
  logic [7:0]    rev;

  always_comb
    for (int i = 0; i < 8; i++) rev[i] = s_data[7-i];

  assign busy    = (state != S_IDLE);
  assign s_ready = (state == S_STREAM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      last_q      <= 1'b0;
      cfg_prog_n  <= 1'b1;
      cfg_write_n <= 1'b1;
      cfg_cs_n    <= 1'b1;
      cfg_led_n   <= 1'b1;
      cfg_data    <= '0;
      ok          <= 1'b0;
      err_reset   <= 1'b0;
      err_init_to <= 1'b0;
      err_crc     <= 1'b0;
      err_done    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          cfg_prog_n  <= 1'b0;
          cfg_write_n <= 1'b1;
          cfg_led_n   <= 1'b1;
          cnt         <= '0;
          ok          <= 1'b0;
          err_reset   <= 1'b0;
          err_init_to <= 1'b0;
          err_crc     <= 1'b0;
          err_done    <= 1'b0;
          state       <= S_PROG;
        end
        S_PROG: begin
          if (cnt == CW'(PROG_CYC - 1)) begin
            cnt <= '0;
            if (cfg_init_n || cfg_done) begin
              err_reset <= 1'b1;
              state     <= S_IDLE;
            end else begin
              cfg_prog_n <= 1'b1;
              state      <= S_WAIT;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_WAIT: begin
          if (cfg_init_n) begin
            cfg_write_n <= 1'b0;
            cfg_led_n   <= 1'b0;
            state       <= S_STREAM;
          end else if (cnt == CW'(TO_CYC - 1)) begin
            err_init_to <= 1'b1;
            cfg_prog_n  <= 1'b0;
            state       <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_STREAM: if (s_valid) begin
          cfg_data <= rev;
          last_q   <= s_last;
          state    <= S_SETUP;
        end
        S_SETUP: begin
          cfg_cs_n <= 1'b0;
          state    <= S_STROBE;
        end
        S_STROBE: begin
          cfg_cs_n <= 1'b1;
          state    <= S_HOLD;
        end
        S_HOLD: state <= last_q ? S_CHECK : S_STREAM;
        S_CHECK: begin
          cfg_write_n <= 1'b1;
          cfg_led_n   <= 1'b1;
          state       <= S_IDLE;
          if (!cfg_init_n) begin
            err_crc    <= 1'b1;
            cfg_prog_n <= 1'b0;
          end else if (!cfg_done) begin
            err_done   <= 1'b1;
            cfg_prog_n <= 1'b0;
          end else ok <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [31:0] chk_low;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) chk_low <= '0;
    else if (cfg_prog_n) chk_low <= '0;
    else if (chk_low != 32'hFFFF_FFFF) chk_low <= chk_low + 1'b1;

  assert_prog_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_prog_n) |-> chk_low >= PROG_CYC);
  assert_reset_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_reset) |-> !cfg_prog_n && cfg_write_n && !s_ready);
  assert_write_after_init_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cfg_write_n) || $fell(cfg_led_n)) |-> $past(cfg_init_n));
  assert_strobe_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_cs_n |=> cfg_cs_n);
  assert_data_before_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_cs_n |-> $stable(cfg_data));
  assert_data_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_cs_n |=> $stable(cfg_data));
  assert_success_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok) |-> cfg_prog_n && cfg_write_n && cfg_led_n);
  assert_fail_park_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_init_to || err_crc || err_done) |-> !cfg_prog_n && cfg_write_n && cfg_led_n);
  assert_ready_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> busy && !cfg_write_n && cfg_cs_n);
  assert_one_status_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ok, err_reset, err_init_to, err_crc, err_done}));
endmodule

// File: tb/fpga_cfg_loader_bench.sv
module fpga_cfg_loader_bench;
  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] s_data = 0;
  logic s_valid = 0, s_last = 0;
  logic s_ready, cfg_prog_n, cfg_write_n, cfg_cs_n, cfg_led_n;
  logic [7:0] cfg_data;
  logic cfg_init_n = 1, cfg_done = 1;
  logic busy, ok, err_reset, err_init_to, err_crc, err_done;

  fpga_cfg_loader u_fpga_cfg_loader (.*);

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  int rmode = 0, nexp = 0, nbytes = 0, dly = 0, plow = 0, nrise = 0;
  bit was_low = 0, released = 0;
  longint cyc = 0;

  task automatic check(input bit c, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!c) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  // target responder; modes: 0 good, 1 crc, 2 no done, 3 init stuck, 4 done stuck
  always @(negedge clk) begin
    cyc++;
    if (!cfg_prog_n) begin
      was_low = 1; released = 0; dly = 0; nbytes = 0;
      cfg_init_n = 0;
      cfg_done = (rmode == 4);
    end else if (was_low && !released) begin
      dly++;
      if (dly >= 20 && rmode != 3) begin cfg_init_n = 1; released = 1; end
    end else if (released && !cfg_cs_n) begin
      nbytes++;
      if (nbytes == nexp) begin
        if (rmode == 1) cfg_init_n = 0;
        else if (rmode != 2) cfg_done = 1;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n && !cfg_cs_n) begin
    if (exp_q.size() == 0) check(0, "R6 extra strobe", cfg_data, -1);
    else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      check(cfg_data == e, "R7 byte", cfg_data, e);
    end
  end

  // program pulse width
  always @(negedge clk) if (rst_n) begin
    if (!cfg_prog_n) plow++;
    else begin
      if (plow > 0) begin check(plow >= 15, "R2 pulse width", plow, 15); nrise++; end
      plow = 0;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle(output longint took);
    longint t0 = cyc;
    while (busy) @(negedge clk);
    took = cyc - t0;
  endtask

  task automatic send_image(input int n, input int seed, input int mode, input bit poke);
    longint t;
    bit first = 1;
    rmode = mode; nexp = n;
    pulse_start();
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = (i == 0) ? 8'h01 : (i == 1) ? 8'h0F : 8'((seed * 37) + i * 29 + 3);
      exp_q.push_back(rev8(b));
      s_data = b; s_valid = 1; s_last = (i == n - 1);
      while (!s_ready) @(negedge clk);
      if (first) begin
        check(!cfg_write_n && !cfg_led_n, "R5 write/led on", {cfg_write_n, cfg_led_n}, 0);
        first = 0;
      end
      @(negedge clk);
      s_valid = 0;
      if (poke && i == 1) begin start = 1; @(negedge clk); start = 0; end
    end
    s_last = 0;
    wait_idle(t);
    check(exp_q.size() == 0, "R6 byte count", exp_q.size(), 0);
  endtask

  task automatic status_is(input logic [4:0] e, input string req);
    check({ok, err_reset, err_init_to, err_crc, err_done} == e, req,
          {ok, err_reset, err_init_to, err_crc, err_done}, e);
  endtask

  initial begin
    longint took;
    int r0;
    repeat (3) @(negedge clk);
    check({cfg_prog_n, cfg_write_n, cfg_cs_n, cfg_led_n} == 4'hF, "R1 pins", {cfg_prog_n, cfg_write_n, cfg_cs_n, cfg_led_n}, 15);
    check(!busy && !s_ready, "R1 busy/ready", {busy, s_ready}, 0);
    status_is(5'b0, "R1 status");
    rst_n = 1;
    repeat (2) @(negedge clk);

    send_image(16, 1, 0, 0);
    status_is(5'b10000, "R9 success");
    check(cfg_prog_n && cfg_write_n && cfg_led_n, "R10 idle pins", {cfg_prog_n, cfg_write_n, cfg_led_n}, 7);
    check(!s_ready, "R12 ready idle", s_ready, 0);

    r0 = nrise;
    send_image(6, 5, 0, 1);
    status_is(5'b10000, "R12 start ignored");
    check(nrise == r0 + 1, "R12 single reset", nrise - r0, 1);

    send_image(9, 7, 1, 0);
    status_is(5'b00010, "R9 crc");
    check(!cfg_prog_n && cfg_write_n && cfg_led_n, "R11 crc park", {cfg_prog_n, cfg_write_n, cfg_led_n}, 3);

    send_image(5, 9, 2, 0);
    status_is(5'b00001, "R9 done low");
    check(!cfg_prog_n && cfg_write_n && cfg_led_n, "R11 done park", {cfg_prog_n, cfg_write_n, cfg_led_n}, 3);

    rmode = 3; nexp = 0;
    pulse_start();
    check(ok == 0 && err_done == 0, "R13 flags cleared", {ok, err_done}, 0);
    repeat (200) @(negedge clk);
    check(busy && cfg_write_n && cfg_led_n, "R4 waiting", {busy, cfg_write_n, cfg_led_n}, 7);
    wait_idle(took);
    status_is(5'b00100, "R4 timeout");
    check(took + 200 >= 5000 && took + 200 <= 5030, "R4 timeout length", took + 200, 5015);
    check(!cfg_prog_n && cfg_write_n && cfg_led_n, "R11 timeout park", {cfg_prog_n, cfg_write_n, cfg_led_n}, 3);

    rmode = 4;
    pulse_start();
    wait_idle(took);
    status_is(5'b01000, "R3 reset fail");
    check(!cfg_prog_n && !s_ready, "R3 held in reset", {cfg_prog_n, s_ready}, 0);

    send_image(12, 11, 0, 0);
    status_is(5'b10000, "R9 recovery");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_bad++; n_cmp++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule